// File: doc/BRIEF.md
# Radio Transmitter Boot Sequencer

This block walks a low-power radio transceiver from power-off to live transmission. Software sets a mode register and a power-amplifier register through a simple write port. An external enable pin must agree with the mode register's enable bit. The block then runs a fixed sequence. It first powers the regulators and the reference oscillator. It waits for the oscillator level to be good. It counts a programmable settle delay, then runs a fixed internal setup interval. Finally it starts the PLL and waits for lock.

When lock is seen, the lock-detect output rises. From then on the modulation data reaches the PA output, unless software cleared the PA-enable bit beforehand. If lock does not come within a timeout, a sticky failure flag is raised and the PA stays shut. All intervals are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `txboot_seq`

## Requirements
- R1: After reset all outputs are low. The mode register (address 0x0A) has enable bit 7 = 0, active bit 6 = 0 and delay code bits [2:0] = 0. The PA-enable bit (address 0x13, bit 1) is 1.
- R2: With `en_pin` high and the enable bit 1, the block leaves off one cycle after the enable bit is seen. It then holds `reg_en` and `osc_en` high. While the active bit is 0, `pll_start` stays low.
- R3: After the active bit is set, the block waits for the oscillator. No timing progress is made while `osc_ok` is low. The settle delay starts on the edge on which `osc_ok` is seen high.
- R4: The settle delay lasts floor(T*CLK_KHZ/10000) cycles, where T in tenths of a microsecond is 1055, 2111, 3165, 5275 or 9495 for codes 0 to 4. Codes 5 to 7 use the code-0 value.
- R5: After the delay, a setup interval of CLK_KHZ/20 cycles (0.05 ms) runs, and then `pll_start` rises. Counted from the edge that captures the active bit, `pll_start` is high after 2 + delay + setup edges when `osc_ok` is already high.
- R6: While the PLL lock is awaited, `pll_lock_in` seen high at an edge makes `lock_det` high from that edge on.
- R7: `pa_out` equals `mod_data` while `lock_det` is high and the PA-enable bit is 1. It is low at all other times, and never high before `lock_det`.
- R8: If the PA-enable bit is written 0, `pa_out` stays low after lock.
- R9: `en_pin` low or a cleared enable bit returns the block to off on the next edge. All outputs then go low.
- R10: Clearing only the active bit returns a running block to standby on the next edge. `reg_en` stays high; `pll_start`, `lock_det` and `pa_out` go low.
- R11: If no lock is seen within LOCK_TMO_US*CLK_KHZ/1000 cycles of `pll_start`, then `lock_fail` rises and `pll_start` drops. `lock_fail` stays high through standby and clears only one edge after the block is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | External enable pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| osc_ok | input | 1 | Reference oscillator level good |
| pll_lock_in | input | 1 | PLL lock indication from the synthesizer |
| mod_data | input | 1 | Modulation data |
| reg_en | output | 1 | Regulator enable |
| osc_en | output | 1 | Reference oscillator enable |
| pll_start | output | 1 | PLL run request |
| lock_det | output | 1 | Lock-detect indication |
| pa_out | output | 1 | Gated modulation data to the PA |
| lock_fail | output | 1 | Sticky lock-timeout flag |

## Verification
The boot is run once for each of the eight delay codes. This separates the five real delay lengths and shows that the three reserved codes fall back to code 0. A run that holds `osc_ok` low separates waiting for the oscillator from counting, because the measured boot time then starts at the `osc_ok` rise. Toggling `mod_data` before and after lock, with the PA bit set and then cleared, tells a correct gate from one that opens early or ignores the bit. A run that never locks, followed by clearing only the active bit and then the enable bit, shows the timeout and that `lock_fail` survives standby but not off.

// File: rtl/txboot_seq.sv
module txboot_seq #(
  parameter int CLK_KHZ = 200000,
  parameter int LOCK_TMO_US = 200,
  parameter logic [7:0] MODE_ADDR = 8'h0A,
  parameter logic [7:0] PA_ADDR = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       osc_ok,
  input  logic       pll_lock_in,
  input  logic       mod_data,
  output logic       reg_en,
  output logic       osc_en,
  output logic       pll_start,
  output logic       lock_det,
  output logic       pa_out,
  output logic       lock_fail
);
  localparam int D0 = (1055 * CLK_KHZ) / 10000;
  localparam int D1 = (2111 * CLK_KHZ) / 10000;
  localparam int D2 = (3165 * CLK_KHZ) / 10000;
  localparam int D3 = (5275 * CLK_KHZ) / 10000;
  localparam int D4 = (9495 * CLK_KHZ) / 10000;
  localparam int SETUP_C = CLK_KHZ / 20;
  localparam int TMO_C = (LOCK_TMO_US * CLK_KHZ) / 1000;
  localparam int M1 = (D4 > SETUP_C) ? D4 : SETUP_C;
  localparam int MAXC = (M1 > TMO_C) ? M1 : TMO_C;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_OFF, S_STBY, S_OSC, S_DLY, S_SET, S_LOCK, S_RUN, S_FAIL} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic enb, act, pa_en;
  logic [2:0] dsel;
  int dly_c;
  logic on_req;
  logic unused_bits;

  assign unused_bits = ^wr_data[5:3];
  assign on_req = en_pin & enb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enb <= 1'b0;
      act <= 1'b0;
      dsel <= 3'd0;
      pa_en <= 1'b1;
    end else if (wr_en) begin
      if (wr_addr == MODE_ADDR) begin
        enb <= wr_data[7];
        act <= wr_data[6];
        dsel <= wr_data[2:0];
      end
      if (wr_addr == PA_ADDR) pa_en <= wr_data[1];
    end
  end

  always_comb begin
    case (dsel)
      3'd1: dly_c = D1;
      3'd2: dly_c = D2;
      3'd3: dly_c = D3;
      3'd4: dly_c = D4;
      default: dly_c = D0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF;
      cnt <= '0;
      lock_fail <= 1'b0;
    end else begin
      if (st == S_OFF) lock_fail <= 1'b0;
      if (!on_req) st <= S_OFF;
      else if (!act && st != S_OFF && st != S_STBY) st <= S_STBY;
      else begin
        case (st)
          S_OFF: st <= S_STBY;
          S_STBY: if (act) st <= S_OSC;
          S_OSC:
            if (osc_ok) begin
              st <= S_DLY;
              cnt <= CW'(dly_c - 1);
            end
          S_DLY:
            if (cnt == '0) begin
              st <= S_SET;
              cnt <= CW'(SETUP_C - 1);
            end else cnt <= cnt - CW'(1);
          S_SET:
            if (cnt == '0) begin
              st <= S_LOCK;
              cnt <= CW'(TMO_C - 1);
            end else cnt <= cnt - CW'(1);
          S_LOCK:
            if (pll_lock_in) st <= S_RUN;
            else if (cnt == '0) begin
              st <= S_FAIL;
              lock_fail <= 1'b1;
            end else cnt <= cnt - CW'(1);
          default: ;
        endcase
      end
    end
  end

  assign reg_en = (st != S_OFF);
  assign osc_en = (st != S_OFF);
  assign pll_start = (st == S_LOCK) || (st == S_RUN);
  assign lock_det = (st == S_RUN);
  assign pa_out = lock_det & pa_en & mod_data;

  a_r7_pa_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    pa_out |-> lock_det);
  a_r6_lock_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_det) |-> $past(pll_start) && $past(pll_lock_in));
  a_r9_pin_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pin |=> !reg_en && !lock_det && !pa_out);
  a_r10_act_clear_stby: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && enb && !act) |=> reg_en && !pll_start);
  a_r11_fail_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_fail) |-> $past(pll_start) && !pll_start);
  a_r11_fail_clears_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_fail) |-> $past(!reg_en));
endmodule

// File: tb/test_txboot_seq.sv
`timescale 1ns/1ps
module test_txboot_seq;
  localparam int KHZ = 1000;
  localparam int TMO_US = 100;
  localparam int SET_C = KHZ / 20;
  localparam int TMO_C = (TMO_US * KHZ) / 1000;

  logic clk = 0, rst_n = 0, en_pin = 0, wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic osc_ok = 0, pll_lock_in = 0, mod_data = 0;
  wire reg_en, osc_en, pll_start, lock_det, pa_out, lock_fail;

  txboot_seq #(.CLK_KHZ(KHZ), .LOCK_TMO_US(TMO_US)) i_txboot_seq (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .osc_ok(osc_ok), .pll_lock_in(pll_lock_in), .mod_data(mod_data),
    .reg_en(reg_en), .osc_en(osc_en), .pll_start(pll_start), .lock_det(lock_det),
    .pa_out(pa_out), .lock_fail(lock_fail));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 0;

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int dly_of(int code);
    int t;
    case (code)
      1: t = 2111;
      2: t = 3165;
      3: t = 5275;
      4: t = 9495;
      default: t = 1055;
    endcase
    return (t * KHZ) / 10000;
  endfunction

  int ph, left, old_ph, m_dsel;
  bit m_enb, m_act, m_pa, m_fail;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; left = 0; m_enb = 0; m_act = 0; m_dsel = 0; m_pa = 1; m_fail = 0;
    end else begin
      old_ph = ph;
      if (old_ph == 0) m_fail = 0;
      if (!(en_pin && m_enb)) ph = 0;
      else if (!m_act && ph >= 2) ph = 1;
      else begin
        case (ph)
          0: ph = 1;
          1: if (m_act) ph = 2;
          2: if (osc_ok) begin ph = 3; left = dly_of(m_dsel); end
          3: begin left--; if (left == 0) begin ph = 4; left = SET_C; end end
          4: begin left--; if (left == 0) begin ph = 5; left = TMO_C; end end
          5: if (pll_lock_in) ph = 6; else begin left--; if (left == 0) ph = 7; end
          default: ;
        endcase
      end
      if (old_ph == 5 && ph == 7) m_fail = 1;
      if (wr_en && wr_addr == 8'h0A) begin
        m_enb = wr_data[7]; m_act = wr_data[6]; m_dsel = int'(wr_data[2:0]);
      end
      if (wr_en && wr_addr == 8'h13) m_pa = wr_data[1];
    end
  end

  always @(posedge clk) begin
    if (cmp_on) begin
      #1;
      chk("R2 reg_en", reg_en, ph != 0);
      chk("R2 osc_en", osc_en, ph != 0);
      chk("R5 pll_start", pll_start, ph == 5 || ph == 6);
      chk("R6 lock_det", lock_det, ph == 6);
      chk("R7 pa_out", pa_out, (ph == 6 && m_pa && mod_data) ? 1 : 0);
      chk("R7 pa_before_lock", pa_out && !lock_det, 0);
      chk("R11 lock_fail", lock_fail, m_fail);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!pll_start && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  int n;

  initial begin
    step(4);
    rst_n = 1;
    #1;
    chk("R1 reg_en", reg_en, 0);
    chk("R1 pll_start", pll_start, 0);
    chk("R1 lock_det", lock_det, 0);
    chk("R1 pa_out", pa_out, 0);
    chk("R1 lock_fail", lock_fail, 0);
    cmp_on = 1;
    en_pin = 1;
    osc_ok = 1;

    for (int code = 0; code < 8; code++) begin
      wr(8'h0A, 8'h80 | 8'(code));
      step(2);
      chk("R2 standby reg_en", reg_en, 1);
      chk("R2 standby no pll", pll_start, 0);
      wr(8'h0A, 8'hC0 | 8'(code));
      wait_start(n);
      chk("R4 R5 boot cycles", n, 2 + dly_of(code) + SET_C);
      step(3);
      pll_lock_in = 1;
      step(1);
      chk("R6 lock_det", lock_det, 1);
      for (int i = 0; i < 6; i++) begin
        mod_data = i[0];
        #1;
        chk("R7 pa follows data", pa_out, i[0]);
        step(1);
      end
      mod_data = 1;
      wr(8'h0A, 8'h80 | 8'(code));
      step(1);
      chk("R10 stby reg_en", reg_en, 1);
      chk("R10 stby lock_det", lock_det, 0);
      chk("R10 stby pa_out", pa_out, 0);
      pll_lock_in = 0;
      mod_data = 0;
      wr(8'h0A, 8'h00);
      step(1);
      chk("R9 enable bit clear", reg_en, 0);
    end

    osc_ok = 0;
    wr(8'h0A, 8'h80);
    wr(8'h0A, 8'hC0);
    step(8);
    chk("R3 osc wait no pll", pll_start, 0);
    chk("R3 osc wait powered", reg_en, 1);
    osc_ok = 1;
    wait_start(n);
    chk("R3 boot from osc_ok", n, 1 + dly_of(0) + SET_C);
    pll_lock_in = 1;
    mod_data = 1;
    step(2);
    chk("R7 pa on", pa_out, 1);
    en_pin = 0;
    step(1);
    chk("R9 pin off reg_en", reg_en, 0);
    chk("R9 pin off lock_det", lock_det, 0);
    chk("R9 pin off pa_out", pa_out, 0);
    en_pin = 1;
    pll_lock_in = 0;
    mod_data = 0;
    wr(8'h0A, 8'h00);

    wr(8'h13, 8'h00);
    wr(8'h0A, 8'h80);
    wr(8'h0A, 8'hC0);
    wait_start(n);
    pll_lock_in = 1;
    mod_data = 1;
    step(2);
    chk("R8 locked", lock_det, 1);
    chk("R8 pa held off", pa_out, 0);
    wr(8'h0A, 8'h00);
    wr(8'h13, 8'h02);
    pll_lock_in = 0;
    mod_data = 0;

    wr(8'h0A, 8'h80);
    wr(8'h0A, 8'hC0);
    wait_start(n);
    mod_data = 1;
    step(TMO_C + 2);
    chk("R11 fail raised", lock_fail, 1);
    chk("R11 pll stopped", pll_start, 0);
    chk("R11 pa off", pa_out, 0);
    pll_lock_in = 1;
    step(3);
    chk("R11 late lock ignored", lock_det, 0);
    chk("R11 sticky", lock_fail, 1);
    wr(8'h0A, 8'h80);
    step(2);
    chk("R11 kept in standby", lock_fail, 1);
    wr(8'h0A, 8'h00);
    step(2);
    chk("R11 cleared when off", lock_fail, 0);
    pll_lock_in = 0;
    mod_data = 0;

    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule